// File: doc/BRIEF.md
# Video Output Range Limiter

This block post-processes an 8-bit 4:2:2 YCbCr byte stream just before it leaves the chip on a BT.656-style output. Each byte comes with three tags: whether it is a luma or a chroma sample, whether it is part of a timing-reference code, and whether it belongs to a vertical blanking (VBI) line. The block limits every video byte to a selectable code range by clipping it to the nearest bound. It never rescales the data.

Two configuration bits are held in a small register that a synchronous reset loads with its defaults. The range-mode bit selects either the narrow studio range or the wide range. The chroma-blank bit decides whether chroma samples on VBI lines are replaced with the neutral level 0x80. Luma on VBI lines is never blanked, so data carried in luma passes through undistorted. Timing-reference bytes bypass both blanking and clipping. Every other byte is kept clear of the reserved codes 0x00 and 0xFF.

Both stream edges use valid/ready and have a single register stage. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the output byte and its tag hold steady and no new byte is taken.

Top module: `vid_range_limiter`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, the range mode is wide (1) and chroma blanking is on (1).
- R2: With range mode 0, a non-reference luma byte leaves clipped to 16..235: values below 16 become 16 and values above 235 become 235.
- R3: With range mode 0, a non-reference chroma byte leaves clipped to 16..240.
- R4: With range mode 1, every non-reference byte, luma or chroma, leaves clipped to 1..254.
- R5: A non-reference byte already inside the active range leaves unchanged; nothing is rescaled.
- R6: A byte tagged as timing reference (`in_ref`=1) leaves unmodified, including 0x00 and 0xFF, whatever the configuration and VBI tag are.
- R7: With blanking on, a non-reference chroma byte (`in_chroma`=1) on a VBI line (`in_vbi`=1) leaves as 0x80, while a luma byte on a VBI line is only range-limited.
- R8: With blanking off, chroma on VBI lines is only range-limited, exactly as on active lines.
- R9: A byte accepted at a clock edge appears on `out_data` right after that edge with `out_valid`=1. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data` and `out_ref` stay stable.
- R10: A valid output byte whose `out_ref` is 0 is never 0x00 or 0xFF.
- R11: On a clock edge with `cfg_load`=1, the range mode and blank bit are taken from `cfg_range` and `cfg_blank`. Bytes accepted at later edges use the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the configuration bits |
| cfg_range | input | 1 | Range mode: 0 narrow, 1 wide |
| cfg_blank | input | 1 | 1 blanks chroma on VBI lines |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Sample byte |
| in_chroma | input | 1 | 1 for Cb/Cr, 0 for Y |
| in_ref | input | 1 | Byte is part of a timing-reference code |
| in_vbi | input | 1 | Byte lies on a VBI line |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Processed byte |
| out_ref | output | 1 | Output byte is timing-reference |

## Verification
Assertions check four things on every cycle. The output never shows a reserved code outside a reference byte. The clip bounds hold for each mode and sample type. Output bytes are held under back-pressure. The reference bypass and the VBI chroma blanking follow from the byte accepted one edge earlier. The bench scenarios are needed to show exact clip values at and beyond each bound, and that in-range values pass untouched. They also show the reset defaults, that a new configuration takes effect only after it is loaded, and that a blocked input byte is taken once the sink drains.

// File: rtl/vrl_pkg.sv
package vrl_pkg;
  localparam int unsigned SW = 8;
  typedef logic [SW-1:0] samp_t;

  typedef struct packed {
    logic wide;
    logic blank;
  } vrl_cfg_t;

  localparam vrl_cfg_t CFG_DEFAULT = '{wide: 1'b1, blank: 1'b1};
endpackage

// File: rtl/vrl_cfg.sv
module vrl_cfg
  import vrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     range_i,
  input  logic     blank_i,
  output vrl_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_DEFAULT;
    end else if (load) begin
      cfg.wide  <= range_i;
      cfg.blank <= blank_i;
    end
  end

  // R11: a load takes both bits
  a_r11_cfg_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cfg.wide == $past(range_i)) && (cfg.blank == $past(blank_i)));
endmodule

// File: rtl/vrl_sample_proc.sv
module vrl_sample_proc
  import vrl_pkg::*;
#(
  parameter samp_t NAR_LO   = 8'd16,
  parameter samp_t NAR_Y_HI = 8'd235,
  parameter samp_t NAR_C_HI = 8'd240,
  parameter samp_t WIDE_LO  = 8'd1,
  parameter samp_t WIDE_HI  = 8'd254,
  parameter samp_t NEUTRAL  = 8'h80
) (
  input  vrl_cfg_t cfg,
  input  samp_t    din,
  input  logic     is_chroma,
  input  logic     is_ref,
  input  logic     on_vbi,
  output samp_t    dout
);
  samp_t pre, lo, hi, clipped;

  always_comb begin
    pre = (is_chroma && on_vbi && cfg.blank) ? NEUTRAL : din;
    if (cfg.wide) begin
      lo = WIDE_LO;
      hi = WIDE_HI;
    end else begin
      lo = NAR_LO;
      hi = is_chroma ? NAR_C_HI : NAR_Y_HI;
    end
    if (pre < lo)      clipped = lo;
    else if (pre > hi) clipped = hi;
    else               clipped = pre;
    dout = is_ref ? din : clipped;
  end

  always_comb begin
    if (!is_ref && !cfg.wide && !is_chroma)
      a_r2_luma_narrow: assert (dout >= 8'd16 && dout <= 8'd235);
    if (!is_ref && !cfg.wide && is_chroma)
      a_r3_chroma_narrow: assert (dout >= 8'd16 && dout <= 8'd240);
    if (!is_ref && cfg.wide)
      a_r4_wide_bounds: assert (dout >= 8'd1 && dout <= 8'd254);
  end
endmodule

// File: rtl/vrl_out_stage.sv
module vrl_out_stage
  import vrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  samp_t d,
  input  logic  ref_i,
  output logic  out_valid,
  input  logic  out_ready,
  output samp_t q,
  output logic  ref_o
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
      ref_o     <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        q     <= d;
        ref_o <= ref_i;
      end
    end
  end

  // R9: held under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q) && $stable(ref_o)));
  // R10: no reserved code outside reference bytes
  a_r10_no_reserved: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ref_o) |-> (q != 8'h00 && q != 8'hFF));
endmodule

// File: rtl/vid_range_limiter.sv
module vid_range_limiter
  import vrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_load,
  input  logic       cfg_range,
  input  logic       cfg_blank,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_chroma,
  input  logic       in_ref,
  input  logic       in_vbi,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_ref
);
  vrl_cfg_t cfg;
  samp_t    proc_d;

  vrl_cfg u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .range_i(cfg_range), .blank_i(cfg_blank), .cfg(cfg)
  );

  vrl_sample_proc u_proc (
    .cfg(cfg), .din(in_data), .is_chroma(in_chroma),
    .is_ref(in_ref), .on_vbi(in_vbi), .dout(proc_d)
  );

  vrl_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .d(proc_d), .ref_i(in_ref), .out_valid(out_valid),
    .out_ready(out_ready), .q(out_data), .ref_o(out_ref)
  );

  logic take;
  assign take = in_valid && in_ready;

  // R6: reference bytes pass untouched
  a_r6_ref_bypass: assert property (@(posedge clk) disable iff (rst)
    (take && in_ref) |=> (out_valid && out_ref && out_data == $past(in_data)));
  // R7: VBI chroma blanked to neutral
  a_r7_vbi_blank: assert property (@(posedge clk) disable iff (rst)
    (take && !in_ref && in_chroma && in_vbi && cfg.blank) |=> (out_data == 8'h80));
endmodule

// File: tb/sim_vid_range_limiter.sv
`timescale 1ns/1ps
module sim_vid_range_limiter;
  logic clk = 1'b0;
  logic rst;
  logic cfg_load, cfg_range, cfg_blank;
  logic in_valid, in_ready, in_chroma, in_ref, in_vbi;
  logic [7:0] in_data, out_data;
  logic out_valid, out_ready, out_ref;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vid_range_limiter u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_range(cfg_range),
    .cfg_blank(cfg_blank), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chroma(in_chroma), .in_ref(in_ref),
    .in_vbi(in_vbi), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ref(out_ref)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic r, logic b);
    @(negedge clk);
    cfg_load = 1; cfg_range = r; cfg_blank = b;
    @(negedge clk);
    cfg_load = 0;
  endtask

  // send one byte; check output right after the accepting edge
  task automatic send(string req, logic [7:0] d, logic c, logic rf, logic v,
                      logic [7:0] exp);
    @(negedge clk);
    in_valid = 1; in_data = d; in_chroma = c; in_ref = rf; in_vbi = v;
    @(posedge clk); #1;
    in_valid = 0;
    chk({req, " valid"}, out_valid, 1);
    chk({req, " data"}, out_data, exp);
    chk({req, " ref"}, out_ref, rf);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    chk("R1 out_valid", out_valid, 0);
    // defaults: wide + blank
    send("R1 wide default", 8'h00, 0, 0, 0, 8'd1);
    send("R1 blank default", 8'h30, 1, 0, 1, 8'h80);
  endtask

  task automatic t_narrow;
    set_cfg(0, 1);
    send("R2 luma low", 8'd3, 0, 0, 0, 8'd16);
    send("R2 luma high", 8'd250, 0, 0, 0, 8'd235);
    send("R2 luma edge", 8'd236, 0, 0, 0, 8'd235);
    send("R3 chroma low", 8'd15, 1, 0, 0, 8'd16);
    send("R3 chroma high", 8'd255, 1, 0, 0, 8'd240);
    send("R3 chroma 238", 8'd238, 1, 0, 0, 8'd238);
    send("R5 luma mid", 8'd100, 0, 0, 0, 8'd100);
    send("R5 luma 235", 8'd235, 0, 0, 0, 8'd235);
  endtask

  task automatic t_wide;
    set_cfg(1, 0);
    send("R4 luma 0", 8'd0, 0, 0, 0, 8'd1);
    send("R4 luma 255", 8'd255, 0, 0, 0, 8'd254);
    send("R4 chroma 255", 8'd255, 1, 0, 0, 8'd254);
    send("R5 luma 250", 8'd250, 0, 0, 0, 8'd250);
    send("R5 chroma 5", 8'd5, 1, 0, 0, 8'd5);
  endtask

  task automatic t_ref;
    set_cfg(0, 1);
    send("R6 ref FF", 8'hFF, 0, 1, 0, 8'hFF);
    send("R6 ref 00", 8'h00, 1, 1, 1, 8'h00);
    send("R6 ref 9D", 8'h9D, 1, 1, 1, 8'h9D);
  endtask

  task automatic t_vbi;
    set_cfg(1, 1);
    send("R7 chroma vbi", 8'd200, 1, 0, 1, 8'h80);
    send("R7 luma vbi", 8'd255, 0, 0, 1, 8'd254);
    send("R7 luma vbi mid", 8'd77, 0, 0, 1, 8'd77);
    set_cfg(0, 0);
    send("R8 chroma vbi pass", 8'd200, 1, 0, 1, 8'd200);
    send("R8 chroma vbi clip", 8'd250, 1, 0, 1, 8'd240);
    send("R11 narrow now", 8'd2, 0, 0, 0, 8'd16);
  endtask

  task automatic t_backpressure;
    set_cfg(1, 1);
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_data = 8'd50; in_chroma = 0; in_ref = 0; in_vbi = 0;
    @(posedge clk); #1;
    chk("R9 first out", out_data, 50);
    in_data = 8'd60;
    chk("R9 in_ready low", in_ready, 0);
    repeat (2) @(posedge clk);
    #1;
    chk("R9 hold data", out_data, 50);
    chk("R9 hold valid", out_valid, 1);
    @(negedge clk); out_ready = 1;
    @(posedge clk); #1;
    in_valid = 0;
    chk("R9 next byte", out_data, 60);
    @(posedge clk); #1;
    chk("R9 drained", out_valid, 0);
  endtask

  initial begin
    rst = 1; cfg_load = 0; cfg_range = 0; cfg_blank = 0;
    in_valid = 0; in_data = 0; in_chroma = 0; in_ref = 0; in_vbi = 0;
    out_ready = 1;
    t_reset();
    t_narrow();
    t_wide();
    t_ref();
    t_vbi();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule